// File: doc/BRIEF.md
# Clock Gating Power-Down Sequencer

This block sits between a clock synthesizer's ungated clock groups and the chip's clock outputs. It gates each group so that the outputs start and stop cleanly, and it controls the ordered shutdown and restart of the crystal oscillator and the VCO. The groups are a CPU clock, a half-rate CPU clock, a set of stoppable PCI clocks, one free-running PCI clock, a 66 MHz clock, an IOAPIC clock, a reference clock and a 48 MHz clock. All clocks are modelled as digital inputs. The CPU clock input also clocks the sequencer.

Two active-low stop inputs freeze selected groups while the rest keep running. An asynchronous active-low power-down request has priority over both stops. A power-down request stops every output low and waits until each group reports that it is stopped. Only then does the sequencer drop the VCO enable, and after that the oscillator enable. When the request is released, the sequencer enables the oscillator and then the VCO. It counts a stabilisation interval, which is a parameter so that simulation stays short, and only then lets the outputs run again.

Top module: `clkgate_pwr_seq`

## Requirements
- R1: After reset, `osc_en` and `vco_en` are 1. With both stop inputs and `pd_req_n` high, every gated output toggles at the rate of its source.
- R2: When `pci_stop_n` is 0, every output in `pci_out` is stopped and held low within 4 rising edges of `pci_free_in`. When `pci_stop_n` returns to 1, those outputs toggle again within the same latency.
- R3: When `cpu_stop_n` is 0, `cpu_clk_out` and `cpu_half_out` are stopped low within 4 rising edges of `pci_free_in`. They resume when `cpu_stop_n` returns to 1.
- R4: The stop inputs never stop `pci_free_out`, `m66_out`, `apic_out`, `ref_out` or `usb_out`.
- R5: After `pd_req_n` goes low and passes a two-stage synchronizer on `cpu_clk`, every gated output has made its last falling edge before `vco_en` falls. `osc_en` falls exactly one `cpu_clk` cycle after `vco_en`.
- R6: While power-down holds the oscillator off, both stop inputs are don't-care. All outputs stay low, and `osc_en` and `vco_en` stay 0.
- R7: After `pd_req_n` returns high, `osc_en` rises first and `vco_en` rises one `cpu_clk` cycle later. No output rises during the STAB_CYCLES cycles that follow the rise of `osc_en`. After that, the outputs resume as the stop inputs select.
- R8: Every high pulse on every gated output lasts exactly one full high phase of its source clock. No runt or truncated pulse appears on entry to or exit from any stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock source; also clocks the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| pci_stop_n | input | 1 | Active-low stop for the stoppable PCI clocks |
| cpu_stop_n | input | 1 | Active-low stop for the CPU and half-rate CPU clocks |
| cpu_half_in | input | 1 | Half-rate CPU clock source |
| pci_free_in | input | 1 | Free-running PCI clock source |
| pci_in | input | NUM_PCI | Stoppable PCI clock sources |
| m66_in | input | 1 | 66 MHz clock source |
| apic_in | input | 1 | IOAPIC clock source |
| ref_in | input | 1 | Reference clock source |
| usb_in | input | 1 | 48 MHz clock source |
| cpu_clk_out | output | 1 | Gated CPU clock |
| cpu_half_out | output | 1 | Gated half-rate CPU clock |
| pci_free_out | output | 1 | Free-running PCI clock, stopped only by power-down |
| pci_out | output | NUM_PCI | Gated PCI clocks |
| m66_out | output | 1 | Gated 66 MHz clock |
| apic_out | output | 1 | Gated IOAPIC clock |
| ref_out | output | 1 | Gated reference clock |
| usb_out | output | 1 | Gated 48 MHz clock |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |

## Verification
The assertions are checked on every cycle, and they cover the ordering rules:
- The VCO enable falls only once every group reports stopped.
- The oscillator enable never falls while the VCO is on.
- All outputs are low whenever the oscillator is off.
- No free-running group reports a new stop while the sequencer is running.
- The restart state is reached only through a full stabilisation count.

Only the bench's scenarios can show some behaviours. The first is the stop latency measured in free PCI edges. The second is that the stop inputs have no effect during power-down. The third is the quiet window after wake-up. The last is the absence of runt pulses, which the bench checks by timing every high pulse against its source phase. The bench covers every combination of the two stop inputs, both while running and across a full power-down and wake cycle.

// File: rtl/cgps_pkg.sv
`timescale 1ns/1ps
package cgps_pkg;
    typedef enum logic [2:0] {
        ST_RUN            = 3'd0,
        ST_STOPPING       = 3'd1,
        ST_OUTPUTS_LOW    = 3'd2,
        ST_OSC_OFF        = 3'd3,
        ST_WAKE_STABILIZE = 3'd4,
        ST_RESTART        = 3'd5
    } seq_state_e;

    // Index of each clock group within the group vectors
    localparam int unsigned GRP_CPU       = 0;
    localparam int unsigned GRP_CPU_HALF  = 1;
    localparam int unsigned GRP_PCI_FREE  = 2;
    localparam int unsigned GRP_M66       = 3;
    localparam int unsigned GRP_APIC      = 4;
    localparam int unsigned GRP_REF       = 5;
    localparam int unsigned GRP_USB       = 6;
    localparam int unsigned GRP_PCI_BASE  = 7;
    localparam int unsigned NUM_FIXED_GRP = 7;
endpackage

// File: rtl/cgps_sync2.sv
`timescale 1ns/1ps
module cgps_sync2 #(
    parameter int unsigned     WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            stable_q <= RST_VAL;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;
endmodule

// File: rtl/cgps_gate_cell.sv
`timescale 1ns/1ps
module cgps_gate_cell (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en,
    output logic clk_out,
    output logic stopped
);
    logic en_l;

    // The enable is captured only while the source is low, so a change of
    // enable can never cut or create a high phase.
    always_latch begin
        if (!rst_n) begin
            en_l = 1'b0;
        end else if (!clk_in) begin
            en_l = en;
        end
    end

    assign clk_out = clk_in & en_l;
    assign stopped = ~en_l;
endmodule

// File: rtl/cgps_seq.sv
`timescale 1ns/1ps
module cgps_seq
    import cgps_pkg::*;
#(
    parameter int unsigned  NUM_GRP     = 11,
    parameter int unsigned  STAB_CYCLES = 64,
    localparam int unsigned CNT_W       = $clog2(STAB_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_req_s,
    input  logic               pci_stop_s,
    input  logic               cpu_stop_s,
    input  logic [NUM_GRP-1:0] grp_stopped,
    output logic [NUM_GRP-1:0] grp_en,
    output logic               osc_en,
    output logic               vco_en
);
    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic               osc;
        logic               vco;
        logic [NUM_GRP-1:0] en;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      run_like;

    always_comb begin
        r_d      = r_q;
        run_like = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                if (pd_req_s) r_d.st = ST_STOPPING;
            end
            ST_STOPPING: begin
                if (&grp_stopped) begin
                    r_d.st  = ST_OUTPUTS_LOW;
                    r_d.vco = 1'b0;
                end
            end
            ST_OUTPUTS_LOW: begin
                r_d.st  = ST_OSC_OFF;
                r_d.osc = 1'b0;
            end
            ST_OSC_OFF: begin
                if (!pd_req_s) begin
                    r_d.st  = ST_WAKE_STABILIZE;
                    r_d.osc = 1'b1;
                    r_d.cnt = '0;
                end
            end
            ST_WAKE_STABILIZE: begin
                r_d.vco = 1'b1;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(STAB_CYCLES - 1)) r_d.st = ST_RESTART;
            end
            ST_RESTART: begin
                r_d.st = ST_RUN;
            end
            default: r_d.st = ST_STOPPING;
        endcase

        // The enables are registered from the next state, so they never glitch.
        run_like = (r_d.st == ST_RUN) || (r_d.st == ST_RESTART);
        for (int unsigned i = 0; i < NUM_GRP; i++) begin
            if (i == GRP_CPU || i == GRP_CPU_HALF) begin
                r_d.en[i] = run_like & ~cpu_stop_s;
            end else if (i >= GRP_PCI_BASE) begin
                r_d.en[i] = run_like & ~pci_stop_s;
            end else begin
                r_d.en[i] = run_like;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_RUN;
            r_q.cnt <= '0;
            r_q.osc <= 1'b1;
            r_q.vco <= 1'b1;
            r_q.en  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign grp_en = r_q.en;
    assign osc_en = r_q.osc;
    assign vco_en = r_q.vco;

    // R5: VCO turned off only after every group acknowledged its stop
    a_r5_vco_off_all_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en) |-> (&grp_stopped));

    // R5: oscillator goes down only with the VCO already down
    a_r5_osc_after_vco: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> !vco_en);

    // R6: no group enabled anywhere inside the power-down sequence
    a_r6_no_enable_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st inside {ST_STOPPING, ST_OUTPUTS_LOW, ST_OSC_OFF, ST_WAKE_STABILIZE})
        |-> (grp_en == '0));

    // R7: the VCO comes back only with the oscillator running
    a_r7_vco_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en) |-> osc_en);

    // R7: restart entered only from a completed stabilisation count
    a_r7_restart_after_stab: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RESTART) |->
        ($past(r_q.st) == ST_WAKE_STABILIZE) && osc_en && vco_en
        && (r_q.cnt == CNT_W'(STAB_CYCLES)));

    // R4: free-running groups never start a stop while running
    for (genvar g = GRP_PCI_FREE; g <= GRP_USB; g++) begin : g_free_chk
        a_r4_free_not_stopped: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grp_stopped[g]) |-> (r_q.st != ST_RUN));
    end
endmodule

// File: rtl/clkgate_pwr_seq.sv
`timescale 1ns/1ps
module clkgate_pwr_seq
    import cgps_pkg::*;
#(
    parameter int unsigned  NUM_PCI     = 4,
    parameter int unsigned  STAB_CYCLES = 64,
    localparam int unsigned NUM_GRP     = NUM_FIXED_GRP + NUM_PCI
) (
    input  logic               cpu_clk,
    input  logic               rst_n,
    input  logic               pd_req_n,
    input  logic               pci_stop_n,
    input  logic               cpu_stop_n,
    input  logic               cpu_half_in,
    input  logic               pci_free_in,
    input  logic [NUM_PCI-1:0] pci_in,
    input  logic               m66_in,
    input  logic               apic_in,
    input  logic               ref_in,
    input  logic               usb_in,
    output logic               cpu_clk_out,
    output logic               cpu_half_out,
    output logic               pci_free_out,
    output logic [NUM_PCI-1:0] pci_out,
    output logic               m66_out,
    output logic               apic_out,
    output logic               ref_out,
    output logic               usb_out,
    output logic               osc_en,
    output logic               vco_en
);
    logic [NUM_GRP-1:0] src_clk;
    logic [NUM_GRP-1:0] gated_clk;
    logic [NUM_GRP-1:0] grp_en;
    logic [NUM_GRP-1:0] stopped_raw;
    logic [NUM_GRP-1:0] stopped_sync;
    logic [2:0]         ctl_sync;

    assign src_clk = {pci_in, usb_in, ref_in, apic_in, m66_in,
                      pci_free_in, cpu_half_in, cpu_clk};

    // Control inputs: {pd_req_n, pci_stop_n, cpu_stop_n}, idle level high
    cgps_sync2 #(.WIDTH(3), .RST_VAL(3'b111)) u_ctl_sync (
        .clk   (cpu_clk),
        .rst_n (rst_n),
        .d     ({pd_req_n, pci_stop_n, cpu_stop_n}),
        .q     (ctl_sync)
    );

    // Stop acknowledges from every group; cells reset stopped
    cgps_sync2 #(.WIDTH(NUM_GRP), .RST_VAL({NUM_GRP{1'b1}})) u_ack_sync (
        .clk   (cpu_clk),
        .rst_n (rst_n),
        .d     (stopped_raw),
        .q     (stopped_sync)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_cell
        cgps_gate_cell u_cell (
            .clk_in  (src_clk[g]),
            .rst_n   (rst_n),
            .en      (grp_en[g]),
            .clk_out (gated_clk[g]),
            .stopped (stopped_raw[g])
        );
    end

    cgps_seq #(.NUM_GRP(NUM_GRP), .STAB_CYCLES(STAB_CYCLES)) u_seq (
        .clk         (cpu_clk),
        .rst_n       (rst_n),
        .pd_req_s    (~ctl_sync[2]),
        .pci_stop_s  (~ctl_sync[1]),
        .cpu_stop_s  (~ctl_sync[0]),
        .grp_stopped (stopped_sync),
        .grp_en      (grp_en),
        .osc_en      (osc_en),
        .vco_en      (vco_en)
    );

    assign cpu_clk_out  = gated_clk[GRP_CPU];
    assign cpu_half_out = gated_clk[GRP_CPU_HALF];
    assign pci_free_out = gated_clk[GRP_PCI_FREE];
    assign m66_out      = gated_clk[GRP_M66];
    assign apic_out     = gated_clk[GRP_APIC];
    assign ref_out      = gated_clk[GRP_REF];
    assign usb_out      = gated_clk[GRP_USB];
    assign pci_out      = gated_clk[NUM_GRP-1:GRP_PCI_BASE];

    // R6: oscillator off implies every output is held low
    a_r6_outputs_low_osc_off: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        !osc_en |-> (gated_clk == '0));
endmodule

// File: tb/clkgate_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module clkgate_pwr_seq_tb_top;
    localparam int NUM_PCI = 4;
    localparam int STAB    = 64;
    localparam int NG      = 7 + NUM_PCI;

    logic cpu_clk = 1'b0;
    logic rst_n = 1'b0, pd_req_n = 1'b1, pci_stop_n = 1'b1, cpu_stop_n = 1'b1;
    logic cpu_half_in = 1'b0, pci_src = 1'b0, m66_in = 1'b0;
    logic apic_in = 1'b0, ref_in = 1'b0, usb_in = 1'b0;
    logic [NUM_PCI-1:0] pci_in;
    logic pci_free_in;
    logic cpu_clk_out, cpu_half_out, pci_free_out, m66_out, apic_out, ref_out, usb_out;
    logic [NUM_PCI-1:0] pci_out;
    logic osc_en, vco_en;

    assign pci_in      = {NUM_PCI{pci_src}};
    assign pci_free_in = pci_src;

    clkgate_pwr_seq #(.NUM_PCI(NUM_PCI), .STAB_CYCLES(STAB)) dut_i (
        .cpu_clk(cpu_clk), .rst_n(rst_n), .pd_req_n(pd_req_n),
        .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
        .cpu_half_in(cpu_half_in), .pci_free_in(pci_free_in), .pci_in(pci_in),
        .m66_in(m66_in), .apic_in(apic_in), .ref_in(ref_in), .usb_in(usb_in),
        .cpu_clk_out(cpu_clk_out), .cpu_half_out(cpu_half_out),
        .pci_free_out(pci_free_out), .pci_out(pci_out), .m66_out(m66_out),
        .apic_out(apic_out), .ref_out(ref_out), .usb_out(usb_out),
        .osc_en(osc_en), .vco_en(vco_en)
    );

    // Source clocks: 100 MHz CPU, others with distinct high phases
    always #5 cpu_clk = ~cpu_clk;
    initial begin #1; forever #10 cpu_half_in = ~cpu_half_in; end
    initial begin #2; forever #15 pci_src     = ~pci_src;     end
    initial begin #3; forever #8  m66_in      = ~m66_in;      end
    initial begin #4; forever #30 apic_in     = ~apic_in;     end
    initial begin #6; forever #35 ref_in      = ~ref_in;      end
    initial begin #7; forever #11 usb_in      = ~usb_in;      end

    function automatic int half_of(input int g);
        case (g)
            0: return 5;  1: return 10; 2: return 15; 3: return 8;
            4: return 30; 5: return 35; 6: return 11; default: return 15;
        endcase
    endfunction

    function automatic string req_of(input int g);
        if (g <= 1) return "R3";
        if (g >= 7) return "R2";
        return "R4";
    endfunction

    wire [NG-1:0] gv = {pci_out, usb_out, ref_out, apic_out, m66_out,
                        pci_free_out, cpu_half_out, cpu_clk_out};

    int      rise_cnt [NG];
    int      runt_cnt [NG];
    realtime t_rise   [NG];
    realtime t_fall   [NG];
    realtime t_vco_off, t_osc_off, t_osc_on, t_vco_on;
    int      n_chk = 0, n_err = 0;

    initial begin
        for (int g = 0; g < NG; g++) begin
            rise_cnt[g] = 0; runt_cnt[g] = 0; t_rise[g] = 0; t_fall[g] = 0;
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_mon
        always @(posedge gv[g]) begin
            rise_cnt[g] = rise_cnt[g] + 1;
            t_rise[g]   = $realtime;
        end
        always @(negedge gv[g]) begin
            t_fall[g] = $realtime;
            if (rise_cnt[g] > 0 && ($realtime - t_rise[g]) != real'(half_of(g)))
                runt_cnt[g] = runt_cnt[g] + 1;
        end
    end

    always @(negedge vco_en) t_vco_off = $realtime;
    always @(negedge osc_en) t_osc_off = $realtime;
    always @(posedge osc_en) t_osc_on  = $realtime;
    always @(posedge vco_en) t_vco_on  = $realtime;

    task automatic chk(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic measure(input int ns, output int d [NG]);
        int s [NG];
        for (int g = 0; g < NG; g++) s[g] = rise_cnt[g];
        #(ns);
        for (int g = 0; g < NG; g++) d[g] = rise_cnt[g] - s[g];
    endtask

    // Every group runs unless its stop input selects it
    task automatic check_run_pattern(input bit pstop, input bit cstop, input string tag);
        int d [NG];
        measure(1000, d);
        for (int g = 0; g < NG; g++) begin
            bit exp_run = (g <= 1) ? !cstop : (g >= 7) ? !pstop : 1'b1;
            if (exp_run)
                chk(req_of(g), d[g] > 0, {tag, " group toggles"}, d[g], 1);
            else begin
                chk(req_of(g), d[g] == 0, {tag, " group stopped"}, d[g], 0);
                chk(req_of(g), gv[g] == 1'b0, {tag, " stopped low"}, gv[g], 0);
            end
        end
    endtask

    initial begin
        int d [NG];
        #1000000;
        n_err++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int d [NG];
        // R1: reset state
        #33;
        chk("R1", osc_en === 1'b1, "osc_en in reset", osc_en, 1);
        chk("R1", vco_en === 1'b1, "vco_en in reset", vco_en, 1);
        chk("R1", gv == '0, "outputs low in reset", gv, 0);
        rst_n = 1'b1;
        #200;
        check_run_pattern(1'b0, 1'b0, "R1 after reset");

        // R2/R3/R4: sweep of all stop combinations while running
        for (int c = 0; c < 4; c++) begin
            @(negedge cpu_clk);
            pci_stop_n = ~c[0];
            cpu_stop_n = ~c[1];
            repeat (4) @(posedge pci_free_in);
            #1;
            check_run_pattern(c[0], c[1], "stop sweep");
        end

        // R5/R6/R7: power-down cycle under every stop combination
        for (int c = 0; c < 4; c++) begin
            @(negedge cpu_clk);
            pci_stop_n = ~c[0];
            cpu_stop_n = ~c[1];
            repeat (4) @(posedge pci_free_in);
            #3 pd_req_n = 1'b0;
            for (int k = 0; k < 400 && osc_en; k++) @(negedge cpu_clk);
            chk("R5", osc_en == 1'b0, "oscillator shut down", osc_en, 0);
            chk("R5", vco_en == 1'b0, "vco shut down", vco_en, 0);
            for (int g = 0; g < NG; g++)
                chk("R5", t_fall[g] <= t_vco_off, "last output fall before vco off",
                    longint'(t_fall[g]), longint'(t_vco_off));
            chk("R5", (t_osc_off - t_vco_off) == 10.0, "osc off one cycle after vco (ns)",
                longint'(t_osc_off - t_vco_off), 10);

            // R6: stop inputs are don't-care while powered down
            for (int k = 0; k < 4; k++) begin
                pci_stop_n = k[0];
                cpu_stop_n = k[1];
                measure(150, d);
                for (int g = 0; g < NG; g++)
                    chk("R6", d[g] == 0 && gv[g] == 1'b0, "output held low in power-down", d[g], 0);
                chk("R6", !osc_en && !vco_en, "enables held off", {osc_en, vco_en}, 0);
            end
            pci_stop_n = ~c[0];
            cpu_stop_n = ~c[1];

            // R7: wake order and quiet window
            @(negedge cpu_clk);
            pd_req_n = 1'b1;
            @(posedge osc_en);
            measure(STAB * 10 - 2, d);
            for (int g = 0; g < NG; g++)
                chk("R7", d[g] == 0, "no output during stabilisation", d[g], 0);
            chk("R7", (t_vco_on - t_osc_on) == 10.0, "vco on one cycle after osc (ns)",
                longint'(t_vco_on - t_osc_on), 10);
            repeat (4) @(posedge pci_free_in);
            #1;
            check_run_pattern(c[0], c[1], "R7 after wake");
        end

        // R8: glitch-free gating across all transitions above
        for (int g = 0; g < NG; g++)
            chk("R8", runt_cnt[g] == 0, "truncated high pulses", runt_cnt[g], 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule